// File: doc/BRIEF.md
# SPI Master Event and Command Register Front End

This block is the register face of an SPI master. A host reaches it through a simple 32-bit register port. The port holds a global mode register and an event register that shows status. It also holds an interrupt enable register, a command register that launches a transaction, and four per-chip-select configuration words. Two 32-bit data ports lead into a transmit FIFO and out of a receive FIFO. The serial shifter sits outside the block. It takes words from the transmit FIFO with a valid/take handshake, returns received words with a one-cycle put strobe, and pulses a byte-done input for every byte it moves.

The event register carries the live occupancy of both FIFOs and a set of sticky flags. Each flag is set by hardware and cleared when software writes a one to it. Every flag has an enable bit at the same position in the interrupt enable register, and the interrupt line is asserted while any enabled flag is set. Software writes a chip-select index and a byte count minus one to the command register. The block then issues a one-cycle start pulse to the shifter, presents the selected chip select's configuration word, and holds a busy line until the shifter has reported every byte.

Top module: `spi_evt_cmd_regs`

## Requirements
- R1: After reset the mode register reads 0x0000_0403: enable bit 31 = 0, loopback bit 30 = 0, TX threshold field [13:8] = 4, RX threshold field [5:0] = 3. The interrupt enable register reads 0, irq is 0, xfer_busy is 0, and the event register reads 0x0000_0100, with only the TX-not-full flag set.
- R2: A write to offset 0x10 pushes one word into the TX FIFO. Event bits [21:16] show the TX word count. tx_valid is high while the FIFO holds a word, and words leave on tx_data in write order, one per cycle with tx_take high.
- R3: A cycle with rx_put high pushes rx_data into the RX FIFO. Event bits [29:24] show the RX word count. A read of offset 0x14 returns the oldest word and removes it.
- R4: Event bit 9 (RX not empty) and bit 8 (TX not full) are set in every cycle their condition holds. Writing a one to either bit cannot clear it while the condition still holds. Once the condition is gone, writing a one clears the bit.
- R5: Event bits 3:0 are sticky and are cleared only by writing ones to them at offset 0x04. Writing zeros leaves every event bit unchanged.
- R6: A TX write while the TX FIFO is full is dropped. The count stays at the depth, the stored words are unchanged, and event bit 1 is set.
- R7: A read of offset 0x14 while the RX FIFO is empty returns 0 and sets event bit 0. An rx_put while the RX FIFO is full is dropped and sets event bit 2.
- R8: irq is high exactly when some event bit in [9:0] is set and its enable bit at the same position of offset 0x08 is set.
- R9: A command write at offset 0x0C while mode bit 31 is set and no transaction is busy raises xfer_start for exactly one cycle in the following cycle. In that cycle xfer_cs shows command bits [31:30] and xfer_len_m1 shows bits [15:0]. xfer_csmode shows the configuration word at offset 0x20 + 4*cs.
- R10: A command write is ignored, with no start pulse and no change in busy, while mode bit 31 is clear or while a transaction is busy.
- R11: xfer_busy goes high with the start pulse and stays high until len_m1+1 byte_done pulses have arrived. The last of these clears busy and sets event bit 3.
- R12: The mode register keeps bits 31, 30, [13:8] and [5:0], and reads the other bits as 0. The interrupt enable register keeps bits [9:0]. The four configuration words keep all 32 bits. cfg_enable and cfg_loop follow mode bits 31 and 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX at 0x14) |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request |
| cfg_enable | output | 1 | Controller enable (mode bit 31) |
| cfg_loop | output | 1 | Internal loopback select (mode bit 30) |
| tx_data | output | 32 | Head word of the TX FIFO |
| tx_valid | output | 1 | TX FIFO holds at least one word |
| tx_take | input | 1 | Shifter consumes the head TX word |
| rx_data | input | 32 | Word from the shifter |
| rx_put | input | 1 | Push rx_data into the RX FIFO |
| byte_done | input | 1 | Shifter finished one byte |
| xfer_start | output | 1 | One-cycle transaction start |
| xfer_cs | output | 2 | Chip select of the transaction |
| xfer_len_m1 | output | 16 | Byte count minus one |
| xfer_csmode | output | 32 | Configuration word of the selected chip select |
| xfer_busy | output | 1 | Transaction in progress |

## Verification
A wrong FIFO pointer or count shows at the next read of the event register as a wrong occupancy field. It also shows at the next word the scoreboard sees on tx_data or on the RX port as a word out of order. A stuck or wrongly cleared sticky flag shows at irq in the cycle after the interrupt enable write. A byte counter loaded with the wrong value keeps xfer_busy high or drops it one byte_done pulse off from len_m1+1. The bench checks busy after the next-to-last and after the last pulse.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

  localparam logic [5:0] OFF_MODE = 6'h00;
  localparam logic [5:0] OFF_EVT  = 6'h04;
  localparam logic [5:0] OFF_MASK = 6'h08;
  localparam logic [5:0] OFF_CMD  = 6'h0C;
  localparam logic [5:0] OFF_TXP  = 6'h10;
  localparam logic [5:0] OFF_RXP  = 6'h14;
  localparam logic [5:0] OFF_CSM0 = 6'h20;

  localparam int NUM_CS = 4;
  localparam int EVT_W  = 10;

  // event flag positions
  localparam int EB_RXNE  = 9;
  localparam int EB_TXNF  = 8;
  localparam int EB_DONE  = 3;
  localparam int EB_RXOVF = 2;
  localparam int EB_TXOVF = 1;
  localparam int EB_RXUNF = 0;

  localparam logic [31:0] MODE_KEEP  = 32'hC000_3F3F;
  localparam logic [31:0] MODE_RESET = 32'h0000_0403;

  typedef struct packed {
    logic [1:0]  cs;
    logic [15:0] len_m1;
  } cmd_t;

  function automatic logic [5:0] cs_offset(input int idx);
    return OFF_CSM0 + 6'(4 * idx);
  endfunction

  function automatic logic [31:0] evt_word(input logic [EVT_W-1:0] flags,
                                           input logic [5:0] rx_cnt,
                                           input logic [5:0] tx_cnt);
    logic [31:0] w;
    w = '0;
    w[29:24] = rx_cnt;
    w[21:16] = tx_cnt;
    w[EVT_W-1:0] = flags;
    return w;
  endfunction

  function automatic cmd_t cmd_decode(input logic [31:0] w);
    cmd_t c;
    c.cs = w[31:30];
    c.len_m1 = w[15:0];
    return c;
  endfunction

  function automatic logic [16:0] byte_total(input logic [15:0] len_m1);
    return {1'b0, len_m1} + 17'd1;
  endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/spi_evt_unit.sv
module spi_evt_unit
  import spi_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] set_vec,
  input  logic             clr_en,
  input  logic [EVT_W-1:0] clr_vec,
  input  logic [EVT_W-1:0] enable_vec,
  output logic [EVT_W-1:0] flags,
  output logic             irq
);

  logic [EVT_W-1:0] clr_eff;

  assign clr_eff = clr_en ? clr_vec : '0;

  // set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_eff) | set_vec;
  end

  assign irq = |(flags & enable_vec);

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  cmd_t        cmd,
  input  logic        enable,
  input  logic [31:0] csmode [NUM_CS],
  input  logic        byte_done,
  output logic        start,
  output logic [1:0]  cs,
  output logic [15:0] len_m1,
  output logic [31:0] csmode_sel,
  output logic        busy,
  output logic        last_byte
);

  logic [16:0] remain;
  logic        accept;

  assign busy      = (remain != '0);
  assign accept    = cmd_wr && enable && !busy;
  assign last_byte = busy && byte_done && (remain == 17'd1);
  assign csmode_sel = csmode[cs];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start  <= 1'b0;
      cs     <= '0;
      len_m1 <= '0;
      remain <= '0;
    end else begin
      start <= accept;
      if (accept) begin
        cs     <= cmd.cs;
        len_m1 <= cmd.len_m1;
        remain <= byte_total(cmd.len_m1);
      end else if (busy && byte_done) begin
        remain <= remain - 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_evt_cmd_regs.sv
module spi_evt_cmd_regs
  import spi_regs_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        cfg_enable,
  output logic        cfg_loop,
  output logic [31:0] tx_data,
  output logic        tx_valid,
  input  logic        tx_take,
  input  logic [31:0] rx_data,
  input  logic        rx_put,
  input  logic        byte_done,
  output logic        xfer_start,
  output logic [1:0]  xfer_cs,
  output logic [15:0] xfer_len_m1,
  output logic [31:0] xfer_csmode,
  output logic        xfer_busy
);

  logic [31:0]      mode_q;
  logic [EVT_W-1:0] mask_q;
  logic [31:0]      csmode_q [NUM_CS];

  // named internal events
  logic wr_mode, wr_evt, wr_mask, wr_cmd, wr_txp, rd_rxp;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [31:0]   rx_head;
  logic [EVT_W-1:0] evt_set, evt_flags;
  logic tx_overflow, rx_overflow, rx_underflow, last_byte;
  logic mask_any;

  assign wr_mode = bus_wr && (bus_addr == OFF_MODE);
  assign wr_evt  = bus_wr && (bus_addr == OFF_EVT);
  assign wr_mask = bus_wr && (bus_addr == OFF_MASK);
  assign wr_cmd  = bus_wr && (bus_addr == OFF_CMD);
  assign wr_txp  = bus_wr && (bus_addr == OFF_TXP);
  assign rd_rxp  = bus_rd && (bus_addr == OFF_RXP);

  assign tx_overflow  = wr_txp && tx_full;
  assign rx_overflow  = rx_put && rx_full;
  assign rx_underflow = rd_rxp && rx_empty;
  assign mask_any     = |mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      mask_q <= '0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata & MODE_KEEP;
      if (wr_mask) mask_q <= bus_wdata[EVT_W-1:0];
    end
  end

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_csmode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csmode_q[g] <= '0;
        else if (bus_wr && (bus_addr == cs_offset(g))) csmode_q[g] <= bus_wdata;
      end
    end
  endgenerate

  assign cfg_enable = mode_q[31];
  assign cfg_loop   = mode_q[30];

  spi_word_fifo #(.W(32), .DEPTH(DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_txp),
    .wdata (bus_wdata),
    .pop   (tx_take),
    .rdata (tx_data),
    .count (tx_cnt),
    .full  (tx_full),
    .empty (tx_empty)
  );
  assign tx_valid = !tx_empty;

  spi_word_fifo #(.W(32), .DEPTH(DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_put),
    .wdata (rx_data),
    .pop   (rd_rxp),
    .rdata (rx_head),
    .count (rx_cnt),
    .full  (rx_full),
    .empty (rx_empty)
  );

  always_comb begin
    evt_set = '0;
    evt_set[EB_RXNE]  = !rx_empty;
    evt_set[EB_TXNF]  = !tx_full;
    evt_set[EB_DONE]  = last_byte;
    evt_set[EB_RXOVF] = rx_overflow;
    evt_set[EB_TXOVF] = tx_overflow;
    evt_set[EB_RXUNF] = rx_underflow;
  end

  spi_evt_unit u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (evt_set),
    .clr_en     (wr_evt),
    .clr_vec    (bus_wdata[EVT_W-1:0]),
    .enable_vec (mask_q),
    .flags      (evt_flags),
    .irq        (irq)
  );

  spi_xfer_ctrl u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (wr_cmd),
    .cmd        (cmd_decode(bus_wdata)),
    .enable     (cfg_enable),
    .csmode     (csmode_q),
    .byte_done  (byte_done),
    .start      (xfer_start),
    .cs         (xfer_cs),
    .len_m1     (xfer_len_m1),
    .csmode_sel (xfer_csmode),
    .busy       (xfer_busy),
    .last_byte  (last_byte)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_MODE: bus_rdata = mode_q;
      OFF_EVT:  bus_rdata = evt_word(evt_flags, 6'(rx_cnt), 6'(tx_cnt));
      OFF_MASK: bus_rdata = {{(32-EVT_W){1'b0}}, mask_q};
      OFF_RXP:  bus_rdata = rx_empty ? '0 : rx_head;
      default: begin
        for (int i = 0; i < NUM_CS; i++)
          if (bus_addr == cs_offset(i)) bus_rdata = csmode_q[i];
      end
    endcase
  end

endmodule

// File: rtl/spi_evt_cmd_chk.sv
module spi_evt_cmd_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_start,
  input logic          xfer_busy,
  input logic          cfg_enable,
  input logic          irq,
  input logic          mask_any,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);

  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_start_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $past(cfg_enable));

  assert_start_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !$past(xfer_busy));

  assert_busy_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_busy) |-> xfer_start);

  assert_tx_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  assert_rx_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  assert_irq_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_any);

endmodule

bind spi_evt_cmd_regs spi_evt_cmd_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_start (xfer_start),
  .xfer_busy  (xfer_busy),
  .cfg_enable (cfg_enable),
  .irq        (irq),
  .mask_any   (mask_any),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt)
);

// File: tb/spi_evt_cmd_regs_tb.sv
`timescale 1ns/1ps
module spi_evt_cmd_regs_tb_top;

  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, cfg_enable, cfg_loop, tx_valid, xfer_start, xfer_busy;
  logic [31:0] tx_data, xfer_csmode;
  logic tx_take = 1'b0, rx_put = 1'b0, byte_done = 1'b0;
  logic [31:0] rx_data = '0;
  logic [1:0] xfer_cs;
  logic [15:0] xfer_len_m1;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] tx_q [$];
  logic [31:0] rx_q [$];
  int tx_model = 0;
  int rx_model = 0;

  always #10 clk = ~clk;

  spi_evt_cmd_regs #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .cfg_enable(cfg_enable), .cfg_loop(cfg_loop),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_take(tx_take),
    .rx_data(rx_data), .rx_put(rx_put), .byte_done(byte_done),
    .xfer_start(xfer_start), .xfer_cs(xfer_cs), .xfer_len_m1(xfer_len_m1),
    .xfer_csmode(xfer_csmode), .xfer_busy(xfer_busy)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  // driver: TX push records the expectation when the FIFO has room
  task automatic tx_push(input logic [31:0] d);
    if (tx_model < DEPTH) begin tx_q.push_back(d); tx_model++; end
    bus_write(6'h10, d);
  endtask

  task automatic tx_drain(input int n);
    @(posedge clk); #1;
    tx_take = 1'b1;
    repeat (n) @(posedge clk);
    #1 tx_take = 1'b0;
    tx_model -= n;
  endtask

  task automatic rx_feed(input logic [31:0] d);
    if (rx_model < DEPTH) begin rx_q.push_back(d); rx_model++; end
    @(posedge clk); #1;
    rx_put = 1'b1; rx_data = d;
    @(posedge clk); #1;
    rx_put = 1'b0;
  endtask

  // monitor for RX port reads
  task automatic rx_pop_check();
    logic [31:0] d, e;
    bus_read(6'h14, d);
    e = rx_q.pop_front();
    rx_model--;
    check("R3 rx order", d, e);
  endtask

  task automatic pulse_byte();
    @(posedge clk); #1 byte_done = 1'b1;
    @(posedge clk); #1 byte_done = 1'b0;
  endtask

  // monitor: compares every word the shifter takes
  always @(negedge clk) begin
    if (rst_n && tx_take && tx_valid) begin
      if (tx_q.size() == 0) check("R2 tx unexpected word", tx_data, 32'hx);
      else check("R2 tx order", tx_data, tx_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 reset state
    bus_read(6'h00, r); check("R1 mode reset", r, 32'h0000_0403);
    bus_read(6'h08, r); check("R1 mask reset", r, 32'h0);
    bus_read(6'h04, r); check("R1 event reset", r, 32'h0000_0100);
    @(negedge clk);
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    check("R1 busy reset", {31'b0, xfer_busy}, 32'h0);

    // R12 register keeping
    bus_write(6'h00, 32'hFFFF_FFFF);
    bus_read(6'h00, r); check("R12 mode kept bits", r, 32'hC000_3F3F);
    bus_write(6'h00, 32'hC000_0A05);
    bus_read(6'h00, r); check("R12 mode readback", r, 32'hC000_0A05);
    @(negedge clk);
    check("R12 cfg_enable/cfg_loop", {30'b0, cfg_enable, cfg_loop}, 32'h3);
    bus_write(6'h08, 32'hFFFF_FFFF);
    bus_read(6'h08, r); check("R12 mask kept bits", r, 32'h0000_03FF);
    bus_write(6'h08, 32'h0);
    bus_write(6'h28, 32'hDEAD_BEEF);
    bus_read(6'h28, r); check("R12 csmode2 readback", r, 32'hDEAD_BEEF);
    bus_read(6'h24, r); check("R12 csmode1 untouched", r, 32'h0);

    // R2 TX path
    tx_push(32'h1111_0001); tx_push(32'h2222_0002); tx_push(32'h3333_0003);
    bus_read(6'h04, r); check("R2 tx count field", {26'b0, r[21:16]}, 32'd3);
    @(negedge clk); check("R2 tx_valid", {31'b0, tx_valid}, 32'h1);
    tx_drain(3);
    bus_read(6'h04, r); check("R2 tx count after drain", {26'b0, r[21:16]}, 32'd0);

    // R3 / R4 RX path and not-empty flag
    rx_feed(32'hA5A5_0001); rx_feed(32'hA5A5_0002); rx_feed(32'hA5A5_0003);
    bus_read(6'h04, r); check("R3 rx count field", {26'b0, r[29:24]}, 32'd3);
    check("R4 rx not empty set", {31'b0, r[9]}, 32'h1);
    bus_write(6'h04, 32'h0000_0200);
    bus_read(6'h04, r); check("R4 clear ignored while not empty", {31'b0, r[9]}, 32'h1);
    rx_pop_check(); rx_pop_check(); rx_pop_check();
    bus_read(6'h04, r); check("R3 rx count zero", {26'b0, r[29:24]}, 32'd0);
    bus_write(6'h04, 32'h0000_0200);
    bus_read(6'h04, r); check("R4 clear once empty", {31'b0, r[9]}, 32'h0);

    // R7 underflow and RX overflow
    bus_read(6'h14, r); check("R7 empty read returns 0", r, 32'h0);
    bus_read(6'h04, r); check("R7 underflow flag", {31'b0, r[0]}, 32'h1);
    for (int i = 0; i < DEPTH + 1; i++) rx_feed(32'hC000_0000 + i);
    bus_read(6'h04, r); check("R7 rx count at depth", {26'b0, r[29:24]}, DEPTH);
    check("R7 rx overflow flag", {31'b0, r[2]}, 32'h1);
    for (int i = 0; i < DEPTH; i++) rx_pop_check();

    // R6 TX overflow, R4 not-full flag
    for (int i = 0; i < DEPTH + 1; i++) tx_push(32'hE000_0000 + i);
    bus_read(6'h04, r); check("R6 tx count at depth", {26'b0, r[21:16]}, DEPTH);
    check("R6 tx overflow flag", {31'b0, r[1]}, 32'h1);
    bus_write(6'h04, 32'h0000_0100);
    bus_read(6'h04, r); check("R4 not-full cleared while full", {31'b0, r[8]}, 32'h0);
    tx_drain(1);
    bus_read(6'h04, r); check("R4 not-full set again", {31'b0, r[8]}, 32'h1);
    tx_drain(DEPTH - 1);
    check("R6 dropped word never seen", tx_q.size(), 32'd0);

    // R8 interrupt
    bus_write(6'h08, 32'h0000_0001);
    @(negedge clk); check("R8 irq enabled flag", {31'b0, irq}, 32'h1);
    bus_write(6'h08, 32'h0000_0008);
    @(negedge clk); check("R8 irq for clear flag", {31'b0, irq}, 32'h0);
    bus_write(6'h08, 32'h0);

    // R5 write-one-to-clear
    bus_write(6'h04, 32'h0);
    bus_read(6'h04, r); check("R5 zero write keeps", {29'b0, r[2:0]}, 32'h7);
    bus_write(6'h04, 32'h0000_0007);
    bus_read(6'h04, r); check("R5 ones clear", {29'b0, r[2:0]}, 32'h0);
    check("R5 others unchanged", {31'b0, r[8]}, 32'h1);

    // R9 command start
    bus_write(6'h0C, 32'h8000_0002);
    @(negedge clk);
    check("R9 start pulse", {31'b0, xfer_start}, 32'h1);
    check("R9 chip select", {30'b0, xfer_cs}, 32'h2);
    check("R9 length", {16'b0, xfer_len_m1}, 32'h2);
    check("R9 csmode select", xfer_csmode, 32'hDEAD_BEEF);
    check("R11 busy with start", {31'b0, xfer_busy}, 32'h1);
    @(negedge clk);
    check("R9 pulse one cycle", {31'b0, xfer_start}, 32'h0);

    // R10 ignored while busy
    bus_write(6'h0C, 32'h4000_0009);
    @(negedge clk);
    check("R10 no start while busy", {31'b0, xfer_start}, 32'h0);
    check("R10 length unchanged", {16'b0, xfer_len_m1}, 32'h2);

    // R11 byte counting
    pulse_byte(); pulse_byte();
    @(negedge clk); check("R11 busy before last byte", {31'b0, xfer_busy}, 32'h1);
    pulse_byte();
    @(negedge clk); check("R11 idle after last byte", {31'b0, xfer_busy}, 32'h0);
    bus_read(6'h04, r); check("R11 done flag", {31'b0, r[3]}, 32'h1);

    // R10 ignored while disabled
    bus_write(6'h00, 32'h0000_0403);
    bus_write(6'h0C, 32'h0000_0001);
    @(negedge clk);
    check("R10 no start when disabled", {31'b0, xfer_start}, 32'h0);
    check("R10 busy stays low", {31'b0, xfer_busy}, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule